// File: doc/BRIEF.md
# I2C Control-Register Target

This block is an I2C target that lets a host controller read and write nine 8-bit control registers at sub-addresses 00h to 08h. It runs on a fast system clock and oversamples the SCL and SDA lines. Each line first passes a synchronizer and then a stability filter, so short spikes never reach the protocol logic. The upper five bits of the 7-bit device address are fixed. The two low bits come from strap pins, so several instances can share one bus.

A write transfer starts with the device address. The next byte sets the internal register pointer, and every byte after that is stored at the pointer, which then steps forward. A read transfer returns data from the current pointer and also steps it forward after each byte. A random read is therefore a short write that sets the pointer, followed by a repeated START and a read. Registers 00h to 07h appear on a flat output bus for the surrounding logic. Register 08h is read-only and reports three status inputs.

An active-low power-down input forces every register back to its reset value and holds it there. While power-down is low the target ignores the bus completely.

Top module: `i2creg_target`

## Requirements
- R1: The target acknowledges only the 7-bit address {00100b, addr_strap[1], addr_strap[0]}; the eighth bit selects read (1) or write (0). For any other address it gives no ACK, and it ignores every byte up to the next START.
- R2: In a write transfer the byte after the address loads the register pointer from its low four bits. Each following byte, MSB first, is acknowledged and written at the pointer.
- R3: The pointer advances by one after every data byte, whether written or read.
- R4: From 08h, or from any pointer value above 08h, the pointer advances to 00h. Reads at pointers above 08h return 00h, and writes there are acknowledged and discarded.
- R5: A read that has no pointer phase returns data starting at the current pointer. A pointer write followed by a repeated START and a read returns data starting at the new pointer.
- R6: After reset the register values are 00h=01h, 05h=40h, 06h=02h, 07h=1Fh, and 00h in every other register.
- R7: Only these bits can be written: 00h mask 13h, 01h to 03h mask 77h, 04h mask 70h, 05h and 06h mask F7h, 07h mask 1Fh. All other bits read back as 0.
- R8: Register 08h reads {0, status_in[2:0], 0000b}. Writes to 08h are acknowledged and discarded, and they still advance the pointer.
- R9: While pwr_dn_n is low, every register holds its reset value, the pointer returns to 00h, and the target never drives SDA.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_CYC clock cycles has no effect on a transfer.
- R11: When the host answers a read byte with NACK, the target releases SDA and leaves it released until the next START or STOP.
- R12: The target changes its SDA drive only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Active-low power-down; holds registers at their reset values |
| addr_strap | input | 2 | Low two bits of the device address |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| status_in | input | 3 | Status bits reported in register 08h |
| cfg_out | output | 64 | Registers 00h..07h, register n at bits [8n+7:8n] |

## Verification
The embedded assertions check several rules on every clock cycle. SDA is only ever asserted and register writes only ever happen while SCL is low. Power-down restores the reset values and releases SDA. Reserved bits stay zero. A write aimed at the read-only or out-of-range addresses leaves the register bus unchanged. Other behaviour can only be shown by the bench's bus scenarios: address matching against the straps, pointer stepping and wrap-around, current-address and random reads, the release of SDA after a host NACK, and the rejection of spikes on either line.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;
   localparam int NREG   = 9;
   localparam int RO_IDX = NREG - 1;
   localparam int PTR_W  = 4;

   typedef enum logic [2:0] {
      S_IDLE, S_ADDR, S_SUB, S_WR, S_ACK, S_RD, S_MACK
   } bus_st_t;

   function automatic logic [7:0] reg_default(input int idx);
      case (idx)
         0:       return 8'h01;
         5:       return 8'h40;
         6:       return 8'h02;
         7:       return 8'h1F;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] reg_wmask(input int idx);
      case (idx)
         0:       return 8'h13;
         1, 2, 3: return 8'h77;
         4:       return 8'h70;
         5, 6:    return 8'hF7;
         7:       return 8'h1F;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [8*RO_IDX-1:0] default_flat();
      logic [8*RO_IDX-1:0] v;
      for (int i = 0; i < RO_IDX; i++) v[8*i +: 8] = reg_default(i);
      return v;
   endfunction

   function automatic logic [8*RO_IDX-1:0] wmask_flat();
      logic [8*RO_IDX-1:0] v;
      for (int i = 0; i < RO_IDX; i++) v[8*i +: 8] = reg_wmask(i);
      return v;
   endfunction

   function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
      return (p >= PTR_W'(RO_IDX)) ? '0 : p + PTR_W'(1);
   endfunction
endpackage

// File: rtl/i2creg_deglitch.sv
module i2creg_deglitch #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CW = $clog2(FILT_CYC + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("FILT_CYC must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end

   if (FILT_CYC == 1) begin : g_nofilt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= 1'b1;
         else        out_q <= sync_q[SYNC_STAGES-1];
      end
   end else begin : g_filt
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q <= 1'b1;
            cnt_q <= '0;
         end else if (sync_q[SYNC_STAGES-1] == out_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(FILT_CYC - 1)) begin
            out_q <= sync_q[SYNC_STAGES-1];
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign dout = out_q;
endmodule

// File: rtl/i2creg_engine.sv
module i2creg_engine
   import i2creg_pkg::*;
#(
   parameter logic [4:0] DEV_PREFIX = 5'b00100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_dn_n,
   input  logic [1:0]       strap,
   input  logic             scl_f,
   input  logic             sda_f,
   input  logic [7:0]       rdata,
   output logic             sda_oe,
   output logic [PTR_W-1:0] ptr,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_addr,
   output logic [7:0]       wr_data
);
   bus_st_t          st_q, ack_nxt_q;
   logic             scl_d, sda_d, oe_q, wr_q;
   logic [3:0]       bit_q;
   logic [7:0]       sh_q, wd_q;
   logic [PTR_W-1:0] ptr_q, wa_q;

   wire start_c = scl_f & scl_d & sda_d & ~sda_f;
   wire stop_c  = scl_f & scl_d & ~sda_d & sda_f;
   wire rise_c  = scl_f & ~scl_d;
   wire fall_c  = ~scl_f & scl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_IDLE; ack_nxt_q <= S_IDLE; scl_d <= 1'b1; sda_d <= 1'b1;
         oe_q <= 1'b0; wr_q <= 1'b0; bit_q <= '0; sh_q <= '0; wd_q <= '0;
         ptr_q <= '0; wa_q <= '0;
      end else if (!pwr_dn_n) begin
         st_q <= S_IDLE; ack_nxt_q <= S_IDLE; scl_d <= 1'b1; sda_d <= 1'b1;
         oe_q <= 1'b0; wr_q <= 1'b0; bit_q <= '0; sh_q <= '0; wd_q <= '0;
         ptr_q <= '0; wa_q <= '0;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
         wr_q  <= 1'b0;
         if (start_c) begin
            st_q  <= S_ADDR;
            bit_q <= '0;
            oe_q  <= 1'b0;
         end else if (stop_c) begin
            st_q <= S_IDLE;
            oe_q <= 1'b0;
         end else if (rise_c) begin
            case (st_q)
               S_ADDR, S_SUB, S_WR: begin
                  sh_q  <= {sh_q[6:0], sda_f};
                  bit_q <= bit_q + 4'd1;
               end
               S_MACK:  if (sda_f) st_q <= S_IDLE;
               default: ;
            endcase
         end else if (fall_c) begin
            case (st_q)
               S_ADDR: if (bit_q == 4'd8) begin
                  if (sh_q[7:1] == {DEV_PREFIX, strap}) begin
                     oe_q      <= 1'b1;
                     st_q      <= S_ACK;
                     ack_nxt_q <= sh_q[0] ? S_RD : S_SUB;
                  end else begin
                     st_q <= S_IDLE;
                  end
               end
               S_SUB: if (bit_q == 4'd8) begin
                  ptr_q     <= sh_q[PTR_W-1:0];
                  oe_q      <= 1'b1;
                  st_q      <= S_ACK;
                  ack_nxt_q <= S_WR;
               end
               S_WR: if (bit_q == 4'd8) begin
                  wr_q      <= 1'b1;
                  wa_q      <= ptr_q;
                  wd_q      <= sh_q;
                  ptr_q     <= next_ptr(ptr_q);
                  oe_q      <= 1'b1;
                  st_q      <= S_ACK;
                  ack_nxt_q <= S_WR;
               end
               S_ACK: begin
                  bit_q <= '0;
                  st_q  <= ack_nxt_q;
                  if (ack_nxt_q == S_RD) begin
                     sh_q <= rdata;
                     oe_q <= ~rdata[7];
                  end else begin
                     oe_q <= 1'b0;
                  end
               end
               S_RD: if (bit_q == 4'd7) begin
                  oe_q  <= 1'b0;
                  st_q  <= S_MACK;
                  ptr_q <= next_ptr(ptr_q);
               end else begin
                  sh_q  <= {sh_q[6:0], 1'b0};
                  oe_q  <= ~sh_q[6];
                  bit_q <= bit_q + 4'd1;
               end
               S_MACK: begin
                  bit_q <= '0;
                  sh_q  <= rdata;
                  oe_q  <= ~rdata[7];
                  st_q  <= S_RD;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe  = oe_q;
   assign ptr     = ptr_q;
   assign wr_en   = wr_q;
   assign wr_addr = wa_q;
   assign wr_data = wd_q;

   assert_ack_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !scl_f);
   assert_pd_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_dn_n |=> !oe_q);
   assert_wr_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> !scl_f);
endmodule

// File: rtl/i2creg_regfile.sv
module i2creg_regfile
   import i2creg_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pwr_dn_n,
   input  logic                  wr_en,
   input  logic [PTR_W-1:0]      wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [PTR_W-1:0]      rd_addr,
   output logic [7:0]            rd_data,
   input  logic [2:0]            status_in,
   output logic [8*RO_IDX-1:0]   cfg_out
);
   localparam logic [8*RO_IDX-1:0] DEF_FLAT  = default_flat();
   localparam logic [8*RO_IDX-1:0] MASK_FLAT = wmask_flat();

   logic [7:0] regs_q [RO_IDX];

   for (genvar i = 0; i < RO_IDX; i++) begin : g_reg
      localparam logic [7:0] DEF  = reg_default(i);
      localparam logic [7:0] MASK = reg_wmask(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 regs_q[i] <= DEF;
         else if (!pwr_dn_n)                         regs_q[i] <= DEF;
         else if (wr_en && wr_addr == PTR_W'(i))     regs_q[i] <= wr_data & MASK;
      end
      assign cfg_out[8*i +: 8] = regs_q[i];
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < RO_IDX; i++)
         if (rd_addr == PTR_W'(i)) rd_data = regs_q[i];
      if (rd_addr == PTR_W'(RO_IDX)) rd_data = {1'b0, status_in, 4'b0000};
   end

   assert_pd_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_dn_n |=> (cfg_out == DEF_FLAT));
   assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_out & ~MASK_FLAT) == '0);
   assert_ro_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_dn_n && wr_en && wr_addr >= PTR_W'(RO_IDX)) |=> $stable(cfg_out));
endmodule

// File: rtl/i2creg_target.sv
module i2creg_target
   import i2creg_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_CYC    = 3,
   parameter logic [4:0] DEV_PREFIX  = 5'b00100
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pwr_dn_n,
   input  logic [1:0]  addr_strap,
   input  logic        scl_in,
   input  logic        sda_in,
   output logic        sda_oe,
   input  logic [2:0]  status_in,
   output logic [63:0] cfg_out
);
   logic [1:0]       raw, filt;
   logic [PTR_W-1:0] ptr, wr_addr;
   logic [7:0]       rdata, wr_data;
   logic             wr_en;

   assign raw = {sda_in, scl_in};

   for (genvar k = 0; k < 2; k++) begin : g_line
      i2creg_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_flt (
         .clk(clk), .rst_n(rst_n), .din(raw[k]), .dout(filt[k]));
   end

   i2creg_engine #(.DEV_PREFIX(DEV_PREFIX)) u_eng (
      .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .strap(addr_strap),
      .scl_f(filt[0]), .sda_f(filt[1]), .rdata(rdata), .sda_oe(sda_oe),
      .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

   i2creg_regfile u_rf (
      .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(ptr), .rd_data(rdata),
      .status_in(status_in), .cfg_out(cfg_out));
endmodule

// File: tb/tb_i2creg_target.sv
module tb_i2creg_target;
   localparam int Q = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_dn_n = 1'b1;
   logic [1:0]  addr_strap = 2'b00;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [2:0]  status_in = 3'b000;
   logic        sda_oe;
   logic [63:0] cfg_out;
   wire         sda_line = sda_m & ~sda_oe;

   int checks = 0;
   int errors = 0;
   logic [63:0] exp_cfg;
   logic [7:0]  exp_q[$];
   string       tag_q[$];
   logic [7:0]  rd_val;
   event        rd_ev;

   always #10 clk = ~clk;

   i2creg_target dut (
      .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .addr_strap(addr_strap),
      .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
      .status_in(status_in), .cfg_out(cfg_out));

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_reg(input int idx, input logic [7:0] v);
      exp_cfg[8*idx +: 8] = v;
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
   endtask

   // glitch=1: short low pulse on SDA in the high phase of a 1 bit
   task automatic clk_bit(input logic b, input int glitch, output logic s);
      sda_m = b; wq(Q); scl_m = 1'b1; wq(Q / 2);
      if (glitch == 1 && b) begin sda_m = 1'b0; wq(2); sda_m = 1'b1; wq(Q / 2 - 2); end
      else wq(Q / 2);
      s = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input int glitch, output bit ack);
      logic s;
      if (glitch == 2) begin scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(Q); end
      for (int i = 7; i >= 0; i--) clk_bit(b[i], glitch, s);
      clk_bit(1'b1, 0, s);
      ack = !s;
   endtask

   task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string tag);
      bit a;
      send_byte(b, 0, a);
      check(a == exp_ack, tag, 64'(a), 64'(exp_ack));
   endtask

   task automatic read_byte(input bit host_ack);
      logic s;
      logic [7:0] v;
      for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, 0, s); v[i] = s; end
      rd_val = v;
      ->rd_ev;
      clk_bit(!host_ack, 0, s);
   endtask

   task automatic expect_rd(input logic [7:0] v, input string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   initial begin : monitor
      forever begin
         @(rd_ev);
         if (exp_q.size() == 0) check(1'b0, "read with empty scoreboard", 64'(rd_val), 64'h0);
         else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(rd_val == e, t, 64'(rd_val), 64'(e));
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      bit a;
      logic s;
      int lows;
      exp_cfg = 64'h1F02_4000_0000_0001;
      wq(5); rst_n = 1'b1; wq(10);
      check(cfg_out == exp_cfg, "R6 reset defaults", cfg_out, exp_cfg);
      check(sda_oe == 1'b0, "R6 SDA released after reset", 64'(sda_oe), 64'h0);

      // current-address read from reset pointer
      expect_rd(8'h01, "R5 current read reg00"); expect_rd(8'h00, "R3 next byte reg01");
      i2c_start(); send_chk(8'h21, 1'b1, "R1 read address ack");
      read_byte(1'b1); read_byte(1'b0); i2c_stop();

      // burst write with masks
      i2c_start(); send_chk(8'h20, 1'b1, "R1 write address ack");
      send_chk(8'h01, 1'b1, "R2 pointer ack");
      send_chk(8'hA5, 1'b1, "R2 data ack"); send_chk(8'hFF, 1'b1, "R3 data ack");
      i2c_stop(); set_reg(1, 8'h25); set_reg(2, 8'h77);
      check(cfg_out == exp_cfg, "R7 masked burst write", cfg_out, exp_cfg);

      // random read
      expect_rd(8'h25, "R5 random read reg01"); expect_rd(8'h77, "R3 reg02");
      expect_rd(8'h00, "R3 reg03");
      i2c_start(); send_chk(8'h20, 1'b1, "R1 ack"); send_chk(8'h01, 1'b1, "R2 ack");
      i2c_start(); send_chk(8'h21, 1'b1, "R5 ack after repeated start");
      read_byte(1'b1); read_byte(1'b1); read_byte(1'b0); i2c_stop();

      // wrap on write through read-only register
      i2c_start(); send_chk(8'h20, 1'b1, "R1 ack"); send_chk(8'h07, 1'b1, "R2 ack");
      send_chk(8'h0A, 1'b1, "R2 ack"); send_chk(8'h55, 1'b1, "R8 write to 08h acked");
      send_chk(8'h33, 1'b1, "R4 ack after wrap"); i2c_stop();
      set_reg(7, 8'h0A); set_reg(0, 8'h13);
      check(cfg_out == exp_cfg, "R4 wrap write 07h->08h->00h", cfg_out, exp_cfg);

      // status register and read wrap
      status_in = 3'b101;
      expect_rd(8'h50, "R8 status register"); expect_rd(8'h13, "R4 read wraps to 00h");
      i2c_start(); send_chk(8'h20, 1'b1, "R1 ack"); send_chk(8'h08, 1'b1, "R2 ack");
      i2c_start(); send_chk(8'h21, 1'b1, "R5 ack");
      read_byte(1'b1); read_byte(1'b0); i2c_stop();

      // pointer above 08h
      i2c_start(); send_chk(8'h20, 1'b1, "R1 ack"); send_chk(8'h0C, 1'b1, "R4 ack");
      send_chk(8'h99, 1'b1, "R4 out-of-range write acked");
      send_chk(8'h02, 1'b1, "R4 ack"); i2c_stop(); set_reg(0, 8'h02);
      check(cfg_out == exp_cfg, "R4 out-of-range write discarded", cfg_out, exp_cfg);
      expect_rd(8'h00, "R4 out-of-range read"); expect_rd(8'h02, "R4 wrap from 0Dh");
      i2c_start(); send_chk(8'h20, 1'b1, "R1 ack"); send_chk(8'h0D, 1'b1, "R2 ack");
      i2c_start(); send_chk(8'h21, 1'b1, "R5 ack");
      read_byte(1'b1); read_byte(1'b0); i2c_stop();

      // strap-selected address
      addr_strap = 2'b10; wq(5);
      i2c_start(); send_chk(8'h20, 1'b0, "R1 wrong address NACK");
      send_chk(8'h02, 1'b0, "R1 ignored byte"); send_chk(8'hFF, 1'b0, "R1 ignored byte");
      i2c_stop();
      check(cfg_out == exp_cfg, "R1 no write after wrong address", cfg_out, exp_cfg);
      i2c_start(); send_chk(8'h24, 1'b1, "R1 strap address ack");
      send_chk(8'h04, 1'b1, "R2 ack"); send_chk(8'hFF, 1'b1, "R2 ack"); i2c_stop();
      set_reg(4, 8'h70);
      check(cfg_out == exp_cfg, "R7 reg04 mask", cfg_out, exp_cfg);

      // host NACK releases SDA
      expect_rd(8'h40, "R3 current read reg05");
      i2c_start(); send_chk(8'h25, 1'b1, "R1 ack"); read_byte(1'b0);
      lows = 0;
      for (int i = 0; i < 9; i++) begin clk_bit(1'b1, 0, s); if (!s) lows++; end
      check(lows == 0, "R11 SDA released after host NACK", 64'(lows), 64'h0);
      i2c_stop();

      // spike rejection
      i2c_start(); send_chk(8'h24, 1'b1, "R1 ack"); send_chk(8'h03, 1'b1, "R2 ack");
      send_byte(8'hF0, 2, a);
      check(a == 1'b1, "R10 ack with SCL spike", 64'(a), 64'h1);
      send_byte(8'hB5, 1, a);
      check(a == 1'b1, "R10 ack with SDA spike", 64'(a), 64'h1);
      i2c_stop(); set_reg(3, 8'h70); set_reg(4, 8'h30);
      check(cfg_out == exp_cfg, "R10 spikes ignored", cfg_out, exp_cfg);

      // power-down
      pwr_dn_n = 1'b0; wq(10);
      exp_cfg = 64'h1F02_4000_0000_0001;
      check(cfg_out == exp_cfg, "R9 defaults in power-down", cfg_out, exp_cfg);
      i2c_start(); send_chk(8'h24, 1'b0, "R9 no ack in power-down"); i2c_stop();
      pwr_dn_n = 1'b1; wq(10);
      expect_rd(8'h01, "R9 pointer back at 00h");
      i2c_start(); send_chk(8'h25, 1'b1, "R1 ack"); read_byte(1'b0); i2c_stop();
      wq(20);
      check(exp_q.size() == 0, "R5 all reads observed", 64'(exp_q.size()), 64'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule